// File: doc/BRIEF.md
# Fast Sinc3 Overcurrent Threshold Detector

This block is the quick-reaction path beside a slow precision converter. It takes the 1-bit output of a delta-sigma modulator, one bit per clock, and decimates it through its own third-order sinc filter with a fixed decimation ratio of 64. Each decimated value is a signed 16-bit code. The block compares every code against a programmable upper limit and a programmable lower limit. A run of consecutive codes beyond a limit must reach a programmed length before the block emits a one-cycle event for that side. No offset or gain correction is applied anywhere in this path.

The filter starts with cleared state when `det_enable` rises. It runs only from that enable and does not depend on any start or stop of the main conversion. The first two decimated values after enable still hold pre-enable history, so they are dropped and neither presented nor compared. Dropping `det_enable` clears the filter, the decimation phase and both run counters. Limits and the qualification length should be changed only while the block is disabled.

Top module: `occ_fast_detector`

## Requirements
- R1: After reset, and on every cycle that follows a cycle with `det_enable` low, `res_valid`, `evt_high` and `evt_low` are 0 whatever `mod_bit` does.
- R2: Counting the clock edges with `det_enable` high since it rose as n = 1, 2, ..., `res_valid` is high after edge n exactly when n >= 192 and n is a multiple of 64. The first two decimation points, at n = 64 and n = 128, produce no output.
- R3: A `mod_bit` value of 1 stands for positive full scale and 0 for negative full scale. When the last 192 bits repeat a 64-bit pattern that holds k ones, the result is 1024*k - 32768 in two's complement. At k = 64 the result saturates to 32767 (0x7FFF), and at k = 0 it is -32768 (0x8000).
- R4: A result counts as beyond the upper limit only when it is strictly greater than `th_high`, both read as signed. A result equal to the limit does not count.
- R5: A result counts as beyond the lower limit only when it is strictly less than `th_low`, both read as signed. A result equal to the limit does not count.
- R6: A `th_high` value of 0x7FFF never produces `evt_high`. A `th_low` value of 0x8000 never produces `evt_low`.
- R7: Upper and lower runs are counted separately. A side's event is a one-cycle pulse, given on the cycle after the `res_valid` of the result that brings that side's run of consecutive beyond-limit results up to `qual_cnt`. The pulse does not repeat while the run goes on, including at the largest count, 31.
- R8: A `qual_cnt` value of 0 behaves as 1, so the first beyond-limit result raises the event.
- R9: A result that is not beyond a limit resets that side's run to zero, so a new event needs a fresh run of `qual_cnt` results.
- R10: Lowering `det_enable` clears the filter state, the decimation phase and both runs. After re-enable, the R2 timing restarts and the first result depends only on bits taken since re-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock; one bitstream sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| det_enable | input | 1 | Runs the detector; low clears all state |
| mod_bit | input | 1 | Modulator bitstream sample |
| th_high | input | 16 | Signed upper limit; 0x7FFF turns upper detection off |
| th_low | input | 16 | Signed lower limit; 0x8000 turns lower detection off |
| qual_cnt | input | 5 | Consecutive beyond-limit results needed for an event (0 acts as 1) |
| res_data | output | 16 | Signed decimated result |
| res_valid | output | 1 | One-cycle strobe marking a new `res_data` |
| evt_high | output | 1 | One-cycle upper-limit event |
| evt_low | output | 1 | One-cycle lower-limit event |

## Verification
A result is due on the same edge that takes in the 64th bit of its frame: edge 192 after enable, and every 64 edges after that. An event is due exactly one edge later than the strobe of the result that completes the run. The bench drives inputs on the falling edge, counts enabled edges itself and compares outputs at the next falling edge. For each strobe it predicts the pulse that must follow one cycle later. Results are compared against the exact steady-state code only when the last 192 bits all came from one pattern. During pattern changes, event prediction runs on the values the block actually produced.

// File: rtl/occ_pkg.sv
package occ_pkg;

    // Default decimation ratio is 2**OCC_OSR_LOG
    localparam int OCC_OSR_LOG = 6;
    // Number of integrator / comb stages
    localparam int OCC_ORDER   = 3;
    // Width of a decimated result
    localparam int OCC_RES_W   = 16;
    // Width of the qualification count
    localparam int OCC_QUAL_W  = 5;

    // Which side of a limit counts as beyond it
    typedef enum logic {
        CMP_ABOVE = 1'b0,
        CMP_BELOW = 1'b1
    } cmp_dir_e;

    // One decimated result travelling from filter to qualifiers
    typedef struct packed {
        logic                 valid;
        logic [OCC_RES_W-1:0] data;
    } occ_result_t;

    // Integrator width that holds the full cascade gain without ambiguity
    function automatic int occ_acc_width(input int order, input int osr_log);
        return 1 + order * osr_log;
    endfunction

endpackage

// File: rtl/occ_sinc3_integ.sv
module occ_sinc3_integ
    import occ_pkg::*;
#(
    parameter int ORDER = OCC_ORDER,
    parameter int ACC_W = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             bit_in,
    output logic [ACC_W-1:0] sum_next
);

    // Running sums; modulo 2**ACC_W arithmetic is intended
    logic [ORDER-1:0][ACC_W-1:0] acc_q;
    logic [ORDER-1:0][ACC_W-1:0] acc_d;

    generate
        for (genvar g = 0; g < ORDER; g++) begin : g_stage
            if (g == 0) begin : g_head
                // The bit adds 0 or 1; the offset to a signed code is removed after the comb
                assign acc_d[g] = acc_q[g] + {{(ACC_W-1){1'b0}}, bit_in};
            end else begin : g_tail
                // Chains on the new value of the stage before, so the sum has no pipeline lag
                assign acc_d[g] = acc_q[g] + acc_d[g-1];
            end

            always_ff @(posedge clk) begin
                if (rst || !en) begin
                    acc_q[g] <= '0;
                end else begin
                    acc_q[g] <= acc_d[g];
                end
            end
        end
    endgenerate

    assign sum_next = acc_d[ORDER-1];

endmodule

// File: rtl/occ_sinc3_decim.sv
module occ_sinc3_decim
    import occ_pkg::*;
#(
    parameter int ORDER   = OCC_ORDER,
    parameter int OSR_LOG = OCC_OSR_LOG,
    parameter int ACC_W   = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ACC_W-1:0] sum_in,
    output occ_result_t      result
);

    // Decimation points dropped after enable while the comb history fills
    localparam int SETTLE = ORDER - 1;
    localparam int SET_W  = (SETTLE > 0) ? $clog2(SETTLE + 1) : 1;
    // Bits dropped below the result when taking the top of the comb output
    localparam int SHIFT  = ACC_W - 1 - OCC_RES_W;

    logic [OSR_LOG-1:0]          phase_q;
    logic [SET_W-1:0]            settle_q;
    logic                        tap;
    logic                        settled;
    logic [ORDER:0][ACC_W-1:0]   stage;
    logic [ORDER-1:0][ACC_W-1:0] hist_q;
    logic [OCC_RES_W-1:0]        code;

    // The last bit of a frame enters on this edge
    assign tap     = en && (phase_q == '1);
    assign settled = (settle_q == SET_W'(SETTLE));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Comb chain: each stage subtracts its input from one frame earlier
    assign stage[0] = sum_in;
    generate
        for (genvar g = 0; g < ORDER; g++) begin : g_comb
            assign stage[g+1] = stage[g] - hist_q[g];

            always_ff @(posedge clk) begin
                if (rst || !en) begin
                    hist_q[g] <= '0;
                end else if (tap) begin
                    hist_q[g] <= stage[g];
                end
            end
        end
    endgenerate

    // Comb output lies in 0 .. 2**(ACC_W-1). Scale it, shift it to signed and clip the top code.
    function automatic logic [OCC_RES_W-1:0] to_code(input logic [ACC_W-1:0] raw);
        logic [OCC_RES_W:0] scaled;
        scaled = raw[ACC_W-1:SHIFT];
        if (scaled[OCC_RES_W]) begin
            return {1'b0, {(OCC_RES_W-1){1'b1}}};
        end
        return {~scaled[OCC_RES_W-1], scaled[OCC_RES_W-2:0]};
    endfunction

    assign code = to_code(stage[ORDER]);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            settle_q <= '0;
        end else if (tap && !settled) begin
            settle_q <= settle_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            result <= '0;
        end else begin
            result.valid <= 1'b0;
            if (tap && settled) begin
                result.valid <= 1'b1;
                result.data  <= code;
            end
        end
    end

endmodule

// File: rtl/occ_qualify.sv
module occ_qualify
    import occ_pkg::*;
#(
    parameter cmp_dir_e DIR    = CMP_ABOVE,
    parameter int       QUAL_W = OCC_QUAL_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  occ_result_t          result,
    input  logic [OCC_RES_W-1:0] limit_th,
    input  logic [QUAL_W-1:0]    qual,
    output logic                 event_o
);

    // Code that turns this side off: the extreme no result can pass strictly
    localparam logic [OCC_RES_W-1:0] OFF_CODE = (DIR == CMP_ABOVE) ?
        {1'b0, {(OCC_RES_W-1){1'b1}}} : {1'b1, {(OCC_RES_W-1){1'b0}}};

    logic [QUAL_W-1:0] run_q;
    logic [QUAL_W-1:0] target;
    logic              beyond;
    logic              cmp_hit;

    always_comb begin
        if (DIR == CMP_ABOVE) begin
            cmp_hit = $signed(result.data) > $signed(limit_th);
        end else begin
            cmp_hit = $signed(result.data) < $signed(limit_th);
        end
    end

    assign beyond = (limit_th != OFF_CODE) && cmp_hit;
    assign target = (qual == '0) ? QUAL_W'(1) : qual;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            run_q   <= '0;
            event_o <= 1'b0;
        end else begin
            event_o <= 1'b0;
            if (result.valid) begin
                if (!beyond) begin
                    run_q <= '0;
                end else if (run_q < target) begin
                    // Counts up to the target and holds there, so the event fires once per run
                    run_q   <= run_q + QUAL_W'(1);
                    event_o <= ((run_q + QUAL_W'(1)) == target);
                end
            end
        end
    end

endmodule

// File: rtl/occ_fast_detector.sv
module occ_fast_detector
    import occ_pkg::*;
#(
    parameter int OSR_LOG = OCC_OSR_LOG,
    parameter int ORDER   = OCC_ORDER,
    parameter int QUAL_W  = OCC_QUAL_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 det_enable,
    input  logic                 mod_bit,
    input  logic [OCC_RES_W-1:0] th_high,
    input  logic [OCC_RES_W-1:0] th_low,
    input  logic [QUAL_W-1:0]    qual_cnt,
    output logic [OCC_RES_W-1:0] res_data,
    output logic                 res_valid,
    output logic                 evt_high,
    output logic                 evt_low
);

    localparam int ACC_W = occ_acc_width(ORDER, OSR_LOG);

    logic [ACC_W-1:0]          sum_next;
    occ_result_t               res;
    logic [1:0][OCC_RES_W-1:0] th_vec;
    logic [1:0]                evt_vec;

    occ_sinc3_integ #(
        .ORDER (ORDER),
        .ACC_W (ACC_W)
    ) u_integ (
        .clk      (clk),
        .rst      (rst),
        .en       (det_enable),
        .bit_in   (mod_bit),
        .sum_next (sum_next)
    );

    occ_sinc3_decim #(
        .ORDER   (ORDER),
        .OSR_LOG (OSR_LOG),
        .ACC_W   (ACC_W)
    ) u_decim (
        .clk    (clk),
        .rst    (rst),
        .en     (det_enable),
        .sum_in (sum_next),
        .result (res)
    );

    // Index 0 is the upper side, index 1 the lower side
    assign th_vec = {th_low, th_high};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_side
            occ_qualify #(
                .DIR    ((g == 0) ? CMP_ABOVE : CMP_BELOW),
                .QUAL_W (QUAL_W)
            ) u_qual (
                .clk      (clk),
                .rst      (rst),
                .en       (det_enable),
                .result   (res),
                .limit_th (th_vec[g]),
                .qual     (qual_cnt),
                .event_o  (evt_vec[g])
            );
        end
    endgenerate

    assign res_data  = res.data;
    assign res_valid = res.valid;
    assign evt_high  = evt_vec[0];
    assign evt_low   = evt_vec[1];

endmodule

// File: rtl/occ_fast_detector_chk.sv
module occ_fast_detector_chk
    import occ_pkg::*;
#(
    parameter int OSR_LOG = OCC_OSR_LOG,
    parameter int ORDER   = OCC_ORDER,
    parameter int QUAL_W  = OCC_QUAL_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 det_enable,
    input logic                 mod_bit,
    input logic [OCC_RES_W-1:0] th_high,
    input logic [OCC_RES_W-1:0] th_low,
    input logic [QUAL_W-1:0]    qual_cnt,
    input logic [OCC_RES_W-1:0] res_data,
    input logic                 res_valid,
    input logic                 evt_high,
    input logic                 evt_low
);

    localparam int FIRST_OUT = ORDER * (1 << OSR_LOG);

    // Independent count of enabled edges since enable rose
    logic [31:0] on_edges;

    always_ff @(posedge clk) begin
        if (rst || !det_enable) begin
            on_edges <= '0;
        end else if (on_edges != 32'hFFFF_FFFF) begin
            on_edges <= on_edges + 32'd1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !det_enable |=> (!res_valid && !evt_high && !evt_low)); // R1

    AST_STROBE_GRID: assert property (@(posedge clk) disable iff (rst)
        res_valid == ((on_edges >= 32'(FIRST_OUT)) && (on_edges[OSR_LOG-1:0] == '0))); // R2

    AST_HIGH_STRICT: assert property (@(posedge clk) disable iff (rst)
        evt_high |-> ($past(res_valid) && ($signed($past(res_data)) > $signed($past(th_high))))); // R4

    AST_LOW_STRICT: assert property (@(posedge clk) disable iff (rst)
        evt_low |-> ($past(res_valid) && ($signed($past(res_data)) < $signed($past(th_low))))); // R5

    AST_HIGH_OFF: assert property (@(posedge clk) disable iff (rst)
        ($past(th_high) == 16'h7FFF) |-> !evt_high); // R6

    AST_LOW_OFF: assert property (@(posedge clk) disable iff (rst)
        ($past(th_low) == 16'h8000) |-> !evt_low); // R6

    AST_HIGH_PULSE: assert property (@(posedge clk) disable iff (rst)
        evt_high |=> !evt_high); // R7

    AST_LOW_PULSE: assert property (@(posedge clk) disable iff (rst)
        evt_low |=> !evt_low); // R7

endmodule

bind occ_fast_detector occ_fast_detector_chk #(
    .OSR_LOG (OSR_LOG),
    .ORDER   (ORDER),
    .QUAL_W  (QUAL_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .det_enable (det_enable),
    .mod_bit    (mod_bit),
    .th_high    (th_high),
    .th_low     (th_low),
    .qual_cnt   (qual_cnt),
    .res_data   (res_data),
    .res_valid  (res_valid),
    .evt_high   (evt_high),
    .evt_low    (evt_low)
);

// File: tb/occ_fast_detector_tb.sv
`timescale 1ns/1ps
module occ_fast_detector_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        det_enable = 1'b0;
    logic        mod_bit = 1'b0;
    logic [15:0] th_high = 16'h7FFF;
    logic [15:0] th_low = 16'h8000;
    logic [4:0]  qual_cnt = 5'd1;
    logic [15:0] res_data;
    logic        res_valid;
    logic        evt_high;
    logic        evt_low;

    int checks = 0;
    int fails = 0;
    int gidx = 0;
    int en_cnt = 0;
    int since_chg = 0;
    int exp_val = 0;
    int run_h = 0;
    int run_l = 0;
    int n_valid = 0;
    int n_eh = 0;
    int n_el = 0;
    bit pend_h = 1'b0;
    bit pend_l = 1'b0;
    logic [63:0] pat = '0;

    always #2.5 clk = ~clk;

    occ_fast_detector u_dut (
        .clk        (clk),
        .rst        (rst),
        .det_enable (det_enable),
        .mod_bit    (mod_bit),
        .th_high    (th_high),
        .th_low     (th_low),
        .qual_cnt   (qual_cnt),
        .res_data   (res_data),
        .res_valid  (res_valid),
        .evt_high   (evt_high),
        .evt_low    (evt_low)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // 64-bit pattern with k ones spread evenly
    function automatic logic [63:0] mkpat(input int k);
        logic [63:0] p;
        for (int i = 0; i < 64; i++) begin
            p[i] = (((i + 1) * k) / 64 - (i * k) / 64) != 0;
        end
        return p;
    endfunction

    task automatic set_k(input int k);
        pat = mkpat(k);
        exp_val = (k == 64) ? 32767 : k * 1024 - 32768;
        since_chg = 0;
    endtask

    // One clock: drive at the falling edge, check at the next falling edge
    task automatic tick();
        int v;
        int lim;
        bit eh;
        bit el;
        bit ev;
        mod_bit = pat[gidx % 64];
        eh = pend_h && det_enable && !rst;
        el = pend_l && det_enable && !rst;
        @(posedge clk);
        @(negedge clk);
        gidx++;
        if (det_enable && !rst) begin
            en_cnt++;
            since_chg++;
        end else begin
            en_cnt = 0;
            since_chg = 0;
            run_h = 0;
            run_l = 0;
        end
        check(evt_high == eh, "R7 upper event timing", int'(evt_high), int'(eh));
        check(evt_low == el, "R7 lower event timing", int'(evt_low), int'(el));
        if (evt_high) n_eh++;
        if (evt_low) n_el++;
        pend_h = 1'b0;
        pend_l = 1'b0;
        ev = det_enable && !rst && en_cnt >= 192 && (en_cnt % 64) == 0;
        check(res_valid == ev, "R2 strobe timing", int'(res_valid), int'(ev));
        if (res_valid) begin
            n_valid++;
            v = int'($signed(res_data));
            if (since_chg >= 192) check(v == exp_val, "R3 result value", v, exp_val);
            lim = (qual_cnt == 0) ? 1 : int'(qual_cnt);
            if (v > int'($signed(th_high))) begin
                if (run_h < lim) begin
                    run_h++;
                    if (run_h == lim) pend_h = 1'b1;
                end
            end else run_h = 0;
            if (v < int'($signed(th_low))) begin
                if (run_l < lim) begin
                    run_l++;
                    if (run_l == lim) pend_l = 1'b1;
                end
            end else run_l = 0;
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic start(input int k, input logic [15:0] hi, input logic [15:0] lo, input logic [4:0] q);
        det_enable = 1'b0;
        tick();
        th_high = hi;
        th_low = lo;
        qual_cnt = q;
        set_k(k);
        det_enable = 1'b1;
    endtask

    task automatic t_reset();
        int base;
        rst = 1'b1;
        set_k(32);
        run(4);
        rst = 1'b0;
        check(res_valid == 1'b0, "R1 reset strobe", int'(res_valid), 0);
        check(evt_high == 1'b0 && evt_low == 1'b0, "R1 reset events", int'(evt_high | evt_low), 0);
        base = n_valid;
        run(300);
        check(n_valid == base, "R1 no output while disabled", n_valid - base, 0);
    endtask

    task automatic t_sweep();
        int ks[5] = '{0, 16, 32, 48, 64};
        int bv;
        int be;
        foreach (ks[i]) begin
            start(ks[i], 16'h7FFF, 16'h8000, 5'd1);
            bv = n_valid;
            be = n_eh + n_el;
            run(192 + 64 * 3 + 2);
            check(n_valid - bv == 4, "R3 result count", n_valid - bv, 4);
            check(n_eh + n_el == be, "R6 sentinel limits", n_eh + n_el - be, 0);
        end
    endtask

    task automatic t_high_strict();
        int be;
        start(40, 16'h2000, 16'h8000, 5'd1);
        be = n_eh;
        run(192 + 64 * 3 + 2);
        check(n_eh == be, "R4 equal value is not beyond", n_eh - be, 0);
        start(40, 16'h1FFF, 16'h8000, 5'd2);
        be = n_eh;
        run(192 + 64 * 4 + 2);
        check(n_eh - be == 1, "R4 one event above limit", n_eh - be, 1);
    endtask

    task automatic t_low_strict();
        int be;
        start(24, 16'h7FFF, 16'hE000, 5'd1);
        be = n_el;
        run(192 + 64 * 3 + 2);
        check(n_el == be, "R5 equal value is not beyond", n_el - be, 0);
        start(24, 16'h7FFF, 16'hE001, 5'd3);
        be = n_el;
        run(192 + 64 * 4 + 2);
        check(n_el - be == 1, "R5 one event below limit", n_el - be, 1);
    endtask

    task automatic t_qual_zero();
        int be;
        start(64, 16'h0000, 16'h8000, 5'd0);
        be = n_eh;
        run(193);
        check(n_eh - be == 1, "R8 zero count acts as one", n_eh - be, 1);
    endtask

    task automatic t_qual_max();
        int be;
        start(0, 16'h7FFF, 16'h0000, 5'd31);
        be = n_el;
        run(192 + 64 * 30);
        check(n_el == be, "R7 no event before 31 results", n_el - be, 0);
        tick();
        check(n_el - be == 1, "R7 event on 31st result", n_el - be, 1);
        run(64 * 3);
        check(n_el - be == 1, "R7 no repeat during run", n_el - be, 1);
    endtask

    task automatic t_rerun();
        int be;
        start(48, 16'h0000, 16'h8000, 5'd4);
        be = n_eh;
        run(256);
        set_k(16);
        run(320);
        check(n_eh == be, "R9 broken run gives no event", n_eh - be, 0);
        set_k(48);
        run(386);
        check(n_eh - be == 1, "R9 fresh run gives one event", n_eh - be, 1);
    endtask

    task automatic t_disable();
        int bv;
        int be;
        start(64, 16'h0000, 16'h8000, 5'd1);
        run(150);
        det_enable = 1'b0;
        run(3);
        check(res_valid == 1'b0, "R10 disabled strobe", int'(res_valid), 0);
        set_k(0);
        det_enable = 1'b1;
        bv = n_valid;
        run(191);
        check(n_valid == bv, "R10 timing restarts", n_valid - bv, 0);
        tick();
        check(res_valid == 1'b1, "R10 first result after re-enable", int'(res_valid), 1);
        check(res_data == 16'h8000, "R10 old bits flushed", int'($signed(res_data)), -32768);
        start(64, 16'h0000, 16'h8000, 5'd3);
        be = n_eh;
        run(256);
        det_enable = 1'b0;
        tick();
        det_enable = 1'b1;
        run(256 + 2);
        check(n_eh == be, "R10 run cleared by disable", n_eh - be, 0);
        run(64);
        check(n_eh - be == 1, "R10 event after full new run", n_eh - be, 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_sweep();
        t_high_strict();
        t_low_strict();
        t_qual_zero();
        t_qual_max();
        t_rerun();
        t_disable();
        det_enable = 1'b0;
        run(2);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule